// File: doc/BRIEF.md
# DMA Interrupt Pending Aggregator

This block collects the completion events of a DMA engine built from two groups of eight channels, a normal group and a dedicated group, and turns them into one interrupt line. Every channel raises two kinds of single-cycle event: one when half of its transfer is done, and one when the whole transfer has ended. Each event sets its own bit in a 32-bit pending word, and the pending bits are gated by a 32-bit enable word before they reach the interrupt line.

Software sees two 32-bit registers through a simple read/write port. It typically writes zero to the enable word and all ones to the pending word at start-up. When it takes a channel it sets that channel's end-of-transfer enable bit. In its handler it reads the pending word and writes the same value back, which clears exactly the bits it saw. A pending bit records its event whether or not it is enabled. If an event lands in the same cycle as a clear of its bit, the bit stays set.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset the enable word, the pending word and `irq` are all zero.
- R2: Status bit position is group*16 + channel*2 + kind. Group is 0 for normal and 1 for dedicated, channel runs 0..7, and kind is 0 for half-transfer and 1 for end-of-transfer. So normal channel c uses bits 2c and 2c+1, and dedicated channel c uses bits 16+2c and 17+2c.
- R3: An event pulse sets its pending bit on the next clock edge whatever the enable word holds, and the bit stays set until it is cleared.
- R4: A write to offset 0x4 clears every pending bit whose data bit is one and leaves the bits whose data bit is zero unchanged.
- R5: An event in the same cycle as a clearing write to its bit wins, and the bit stays set.
- R6: A write to offset 0x0 replaces the whole enable word. A read of 0x0 returns the enable word and a read of 0x4 returns the pending word, both combinationally from `reg_addr`.
- R7: `irq` equals the OR over all 32 bits of (pending AND enable) as it stood one clock earlier.
- R8: Reads of any offset other than 0x0 and 0x4 return zero, and writes to them change neither register.
- R9: Writing back the value just read from 0x4 leaves pending zero unless a new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nrm_half_evt | input | 8 | Half-transfer pulses, normal channels |
| nrm_end_evt | input | 8 | End-of-transfer pulses, normal channels |
| ded_half_evt | input | 8 | Half-transfer pulses, dedicated channels |
| ded_end_evt | input | 8 | End-of-transfer pulses, dedicated channels |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench fires events on disabled sources. A design that masked the pending bit rather than the output would lose those events, and the read-back would show zero. It fires an event and a clear of the same bit in one cycle, so a design that gave the clear priority would drop the bit. It pulses the four event kinds at the group and channel edges (normal channel 7, dedicated channel 0 and others), so any swapped kind or group shows as a wrong bit position. It also checks that `irq` lags the enable and pending words by exactly one cycle and that accesses to unmapped offsets neither read back data nor disturb either register.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int OFF_ENABLE  = 'h0;
    localparam int OFF_PENDING = 'h4;
    localparam int KIND_HALF   = 0;
    localparam int KIND_END    = 1;

    // Position of one event in the status word (group-major, channel, kind).
    function automatic int stat_bit(input int grp, input int ch, input int kind,
                                    input int ch_per_grp);
        return grp * (2 * ch_per_grp) + ch * 2 + kind;
    endfunction

endpackage

// File: rtl/dma_irq_evmap.sv
module dma_irq_evmap
    import dma_irq_pkg::*;
#(
    parameter int CH_PER_GRP = 8,
    localparam int STAT_W    = 4 * CH_PER_GRP
) (
    input  logic [CH_PER_GRP-1:0] nrm_half,
    input  logic [CH_PER_GRP-1:0] nrm_end,
    input  logic [CH_PER_GRP-1:0] ded_half,
    input  logic [CH_PER_GRP-1:0] ded_end,
    output logic [STAT_W-1:0]     evt_vec
);

    for (genvar c = 0; c < CH_PER_GRP; c++) begin : g_ch
        assign evt_vec[stat_bit(0, c, KIND_HALF, CH_PER_GRP)] = nrm_half[c];
        assign evt_vec[stat_bit(0, c, KIND_END,  CH_PER_GRP)] = nrm_end[c];
        assign evt_vec[stat_bit(1, c, KIND_HALF, CH_PER_GRP)] = ded_half[c];
        assign evt_vec[stat_bit(1, c, KIND_END,  CH_PER_GRP)] = ded_end[c];
    end

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_vec,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] en_q,
    output logic [STAT_W-1:0] pend_q
);

    typedef struct packed {
        logic [STAT_W-1:0] en;
        logic [STAT_W-1:0] pend;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic        hit_en, hit_pend;

    always_comb begin
        hit_en   = reg_wr && (reg_addr == ADDR_W'(OFF_ENABLE));
        hit_pend = reg_wr && (reg_addr == ADDR_W'(OFF_PENDING));
        st_d     = st_q;
        if (hit_en) begin
            st_d.en = reg_wdata;
        end
        // Clear first, then set: an event beats a simultaneous clear.
        if (hit_pend) begin
            st_d.pend = st_q.pend & ~reg_wdata;
        end
        st_d.pend = st_d.pend | evt_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;

endmodule

// File: rtl/dma_irq_readmux.sv
module dma_irq_readmux
    import dma_irq_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [STAT_W-1:0] en_q,
    input  logic [STAT_W-1:0] pend_q,
    output logic [STAT_W-1:0] reg_rdata
);

    always_comb begin
        case (reg_addr)
            ADDR_W'(OFF_ENABLE):  reg_rdata = en_q;
            ADDR_W'(OFF_PENDING): reg_rdata = pend_q;
            default:              reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator #(
    parameter int CH_PER_GRP = 8,
    parameter int ADDR_W     = 8,
    localparam int STAT_W    = 4 * CH_PER_GRP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH_PER_GRP-1:0] nrm_half_evt,
    input  logic [CH_PER_GRP-1:0] nrm_end_evt,
    input  logic [CH_PER_GRP-1:0] ded_half_evt,
    input  logic [CH_PER_GRP-1:0] ded_end_evt,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic [STAT_W-1:0]     reg_wdata,
    output logic [STAT_W-1:0]     reg_rdata,
    output logic                  irq
);

    logic [STAT_W-1:0] evt_vec;
    logic [STAT_W-1:0] en_q;
    logic [STAT_W-1:0] pend_q;
    logic              irq_d, irq_q;

    dma_irq_evmap #(.CH_PER_GRP(CH_PER_GRP)) u_evmap (
        .nrm_half (nrm_half_evt),
        .nrm_end  (nrm_end_evt),
        .ded_half (ded_half_evt),
        .ded_end  (ded_end_evt),
        .evt_vec  (evt_vec)
    );

    dma_irq_status #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_vec   (evt_vec),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .en_q      (en_q),
        .pend_q    (pend_q)
    );

    dma_irq_readmux #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_rdmux (
        .reg_addr  (reg_addr),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .reg_rdata (reg_rdata)
    );

    always_comb begin
        irq_d = |(pend_q & en_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/dma_irq_checker.sv
module dma_irq_checker
    import dma_irq_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] evt_vec,
    input logic [STAT_W-1:0] en_q,
    input logic [STAT_W-1:0] pend_q,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic              irq
);

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec))); // R3
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_PENDING) && (evt_vec & reg_wdata) != '0)
        |=> ((pend_q & $past(evt_vec & reg_wdata)) == $past(evt_vec & reg_wdata))); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_PENDING) && evt_vec == '0)
        |=> ((pend_q & $past(reg_wdata)) == '0)); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_vec)) == '0)); // R2
    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFF_ENABLE)) |=> (en_q == $past(reg_wdata))); // R6
    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(OFF_ENABLE)) |=> $stable(en_q)); // R8
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(pend_q) & $past(en_q)))); // R7

endmodule

bind dma_irq_aggregator dma_irq_checker #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_vec   (evt_vec),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq       (irq)
);

// File: tb/dma_irq_aggregator_test.sv
`timescale 1ns/1ps
module dma_irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  nh = '0, ne = '0, dh = '0, de = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Behavioural reference state
    logic [31:0] m_en = '0, m_pend = '0;
    logic        m_irq = 1'b0;

    always #5 clk = ~clk;

    dma_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n),
        .nrm_half_evt(nh), .nrm_end_evt(ne), .ded_half_evt(dh), .ded_end_evt(de),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Reference model: bit = group*16 + channel*2 + kind.
    always @(posedge clk) begin
        logic [31:0] ev;
        logic [31:0] np;
        if (!rst_n) begin
            m_en <= '0; m_pend <= '0; m_irq <= 1'b0;
        end else begin
            ev = '0;
            for (int c = 0; c < 8; c++) begin
                if (nh[c]) ev[c*2]        = 1'b1;
                if (ne[c]) ev[c*2 + 1]    = 1'b1;
                if (dh[c]) ev[16 + c*2]   = 1'b1;
                if (de[c]) ev[16 + c*2+1] = 1'b1;
            end
            np = m_pend;
            if (reg_wr && reg_addr == 8'h04) np = np & ~reg_wdata;
            m_pend <= np | ev;
            if (reg_wr && reg_addr == 8'h00) m_en <= reg_wdata;
            m_irq <= |(m_pend & m_en);
        end
    end

    // Every-cycle comparison, well after the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            logic [31:0] exp_rd;
            exp_rd = (reg_addr == 8'h00) ? m_en : (reg_addr == 8'h04) ? m_pend : 32'h0;
            check(irq == m_irq, "R7 irq vs model", {31'h0, irq}, {31'h0, m_irq});
            check(reg_rdata == exp_rd, "R6 rdata vs model", reg_rdata, exp_rd);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic pulse(input int grp, input int ch, input int kind);
        if (grp == 0 && kind == 0) nh[ch] = 1'b1;
        if (grp == 0 && kind == 1) ne[ch] = 1'b1;
        if (grp == 1 && kind == 0) dh[ch] = 1'b1;
        if (grp == 1 && kind == 1) de[ch] = 1'b1;
        tick();
        nh = '0; ne = '0; dh = '0; de = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seen;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(8'h00, 32'h0, "R1 enable after reset");
        rd(8'h04, 32'h0, "R1 pending after reset");
        check(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2/R3 disabled events still latch at the right positions
        pulse(0, 3, 0);
        rd(8'h04, 32'h0000_0040, "R3 normal ch3 half latched while disabled");
        pulse(0, 7, 1);
        rd(8'h04, 32'h0000_8040, "R2 normal ch7 end at bit 15");
        pulse(1, 0, 0);
        rd(8'h04, 32'h0001_8040, "R2 dedicated ch0 half at bit 16");
        pulse(1, 5, 1);
        rd(8'h04, 32'h0801_8040, "R2 dedicated ch5 end at bit 27");
        tick();
        check(irq == 1'b0, "R3 irq stays low while disabled", {31'h0, irq}, 32'h0);

        // R6/R7 enabling a pending source raises irq one cycle after the enable lands
        wr(8'h00, 32'h0800_0000);
        rd(8'h00, 32'h0800_0000, "R6 enable readback");
        check(irq == 1'b0, "R7 irq not yet up", {31'h0, irq}, 32'h0);
        tick();
        check(irq == 1'b1, "R7 irq asserted", {31'h0, irq}, 32'h1);

        // R4 partial write-one-to-clear
        wr(8'h04, 32'h0800_0040);
        rd(8'h04, 32'h0001_8000, "R4 partial clear");
        tick();
        check(irq == 1'b0, "R7 irq falls after clear", {31'h0, irq}, 32'h0);

        // R5 event and clear of the same bit together
        reg_addr = 8'h04; reg_wr = 1'b1; reg_wdata = 32'h0001_8000; ne[7] = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; ne = '0;
        rd(8'h04, 32'h0000_8000, "R5 event beats clear");

        // R8 unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R8 unmapped 0x8 reads zero");
        rd(8'h0C, 32'h0, "R8 unmapped 0xC reads zero");
        rd(8'h00, 32'h0800_0000, "R8 enable untouched by unmapped write");
        rd(8'h04, 32'h0000_8000, "R8 pending untouched by unmapped write");

        // R9 write back what was read
        pulse(1, 2, 0);
        pulse(0, 0, 1);
        reg_addr = 8'h04; #1; seen = reg_rdata;
        check(seen == 32'h0010_8002, "R2 dedicated ch2 half / normal ch0 end", seen, 32'h0010_8002);
        wr(8'h04, seen);
        rd(8'h04, 32'h0, "R9 write-back clears exactly what was seen");

        // R3/R7 enable everything, many events at once, then clear all
        wr(8'h00, 32'hFFFF_FFFF);
        nh = 8'hA5; de = 8'h81;
        tick();
        nh = '0; de = '0;
        rd(8'h04, 32'h8002_4411, "R2 multi-event pattern");
        tick();
        check(irq == 1'b1, "R7 irq with all enabled", {31'h0, irq}, 32'h1);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R4 clear all");
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h0, "R6 enable cleared");
        repeat (2) tick();
        check(irq == 1'b0, "R7 irq low at end", {31'h0, irq}, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule